// File: doc/BRIEF.md
# Two-Wire Programming Port Host Sequencer

This block is the host side of a two-wire serial programming link. A caller hands it one command at a time over a valid/ready handshake. A command either sends a 24-bit instruction word to the target or reads back a 16-bit register value. The block builds the link clock from the system clock through a programmable half-period divider. It shifts out each frame, turns the data line around for the readout window, and returns the captured word with a one-cycle valid pulse.

Frame length depends on the command and on reset history. The first instruction frame after reset carries five extra leading zero clocks ahead of its code. Every later instruction frame, and every read frame, is 28 link clocks long. The caller decides which instructions to send. The caller must also follow every table read or table write instruction with a no-op instruction, because the block inserts nothing of its own.

Top module: `prog_link_host`

## Requirements
- R1: Between frames the link clock is low, the data line is driven (enable high) at 0, and `cmd_ready` is high. A frame begins only in the cycle after a command is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge).
- R2: Each high phase and each low phase of the link clock lasts H system clocks. H is `half_period` sampled at acceptance, and a value of 0 counts as 1.
- R3: The host changes `link_dout` and `link_doe` only when the link clock falls, or at frame start while the clock is already low. Both stay stable while the clock is high.
- R4: Every field is shifted least significant bit first. The instruction word's bit k goes out on the link clock right after the code bits, offset by k.
- R5: An instruction frame is the code 0000 (four clocks at 0) followed by the 24 instruction bits, for 28 link clocks in total.
- R6: The first instruction frame after reset has nine zero clocks in place of the four-clock code, for 33 link clocks in total. Read frames issued before it leave this lengthening pending.
- R7: A read frame sends the code 0001 least significant bit first (1, 0, 0, 0). It then drives eight clocks at 0. It then releases the line (`link_doe` low) for 16 clocks, and drives it again from the end of the frame.
- R8: On the rising link clock edge of each of the 16 released clocks, the host samples `link_din`, least significant bit first. At the frame's end `rd_data` carries the word and `rd_valid` is high for exactly one cycle. `rd_data` then holds its value.
- R9: `cmd_ready` stays low for the whole frame, and a command offered during a frame is ignored. The frame in flight is unchanged and no second frame follows from it.
- R10: A frame occupies exactly 2·H·N system clocks from acceptance until `cmd_ready` returns, where N is the frame's link-clock count. `rd_valid` is asserted only at the end of read frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | HALF_W | Link clock half-period in system clocks (0 treated as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Host idle and able to accept |
| cmd_read | input | 1 | 1 = read register, 0 = send instruction |
| cmd_word | input | 24 | Instruction word for a send command |
| rd_data | output | 16 | Last word read from the target |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| link_clk | output | 1 | Link clock to the target |
| link_dout | output | 1 | Data driven toward the target |
| link_doe | output | 1 | Data line drive enable (0 = released) |
| link_din | input | 1 | Data line as seen from the target |

## Verification
The bench builds the host with HALF_W = 4 and exercises half-period values 0 through 4. Value 1 runs the link at its fastest rate, with a tick on every system clock. Value 0 checks the clamp to one. Values 2 to 4 leave several cycles inside each phase, so a data change while the clock is high, or a phase of the wrong length, becomes visible. Reset is applied twice, so the lengthened first frame is observed once after an instruction opens the session and once after a read has gone first.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;

  localparam int INSN_W    = 24;
  localparam int RD_W      = 16;
  localparam int CODE_W    = 4;
  localparam int WAKE_X    = 5;
  localparam int IDLE_N    = 8;
  localparam int SEND_LEN  = CODE_W + INSN_W;
  localparam int FIRST_LEN = SEND_LEN + WAKE_X;
  localparam int READ_LEN  = CODE_W + IDLE_N + RD_W;
  localparam int MAX_LEN   = FIRST_LEN;
  localparam int IDX_W     = $clog2(MAX_LEN + 1);

  localparam logic [CODE_W-1:0] SEND_CODE = 4'h0;
  localparam logic [CODE_W-1:0] READ_CODE = 4'h1;

  typedef enum logic {K_SEND = 1'b0, K_READ = 1'b1} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              lead;
    logic [INSN_W-1:0] word;
  } frame_t;

  // number of link clocks in a frame
  function automatic logic [IDX_W-1:0] frame_len(frame_t f);
    if (f.kind == K_READ) return IDX_W'(READ_LEN);
    if (f.lead)           return IDX_W'(FIRST_LEN);
    return IDX_W'(SEND_LEN);
  endfunction

  // host-driven bit value for link clock number idx
  function automatic logic frame_bit(frame_t f, logic [IDX_W-1:0] idx);
    int i;
    int pre;
    logic [CODE_W-1:0] c;
    logic [INSN_W-1:0] w;
    i   = int'(idx);
    pre = f.lead ? WAKE_X : 0;
    c   = (f.kind == K_READ) ? READ_CODE : SEND_CODE;
    w   = f.word;
    if (i < pre) return 1'b0;
    if (i < pre + CODE_W) begin
      c = c >> (i - pre);
      return c[0];
    end
    if (f.kind == K_READ) return 1'b0;
    w = w >> (i - pre - CODE_W);
    return w[0];
  endfunction

  // true when the target owns the data line during link clock idx
  function automatic logic frame_listens(frame_t f, logic [IDX_W-1:0] idx);
    return (f.kind == K_READ) && (int'(idx) >= CODE_W + IDLE_N);
  endfunction

endpackage

// File: rtl/prog_link_pace.sv
module prog_link_pace #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);

  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;

  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || tick)    cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/prog_link_frame.sv
module prog_link_frame
  import prog_link_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  frame_t            req,
  input  logic [HALF_W-1:0] half_in,
  input  logic              tick,
  input  logic              link_din,
  output logic              busy,
  output logic [HALF_W-1:0] half_q,
  output logic              link_clk,
  output logic              link_dout,
  output logic              link_doe,
  output logic [RD_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              sample_ev,
  output logic              done_ev
);

  frame_t           cur;
  frame_t           nxt;
  logic             lead_pend;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_n;
  logic [IDX_W-1:0] last;
  logic [RD_W-1:0]  shreg;

  always_comb begin
    nxt      = req;
    nxt.lead = lead_pend && (req.kind == K_SEND);
  end

  assign idx_n     = idx + 1'b1;
  assign last      = frame_len(cur) - 1'b1;
  assign sample_ev = busy && tick && !link_clk && frame_listens(cur, idx);
  assign done_ev   = busy && tick && link_clk && (idx == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      half_q    <= '0;
      cur       <= '0;
      lead_pend <= 1'b1;
      idx       <= '0;
      shreg     <= '0;
      link_clk  <= 1'b0;
      link_dout <= 1'b0;
      link_doe  <= 1'b1;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        half_q    <= half_in;
        cur       <= nxt;
        if (nxt.lead) lead_pend <= 1'b0;
        idx       <= '0;
        link_clk  <= 1'b0;
        link_dout <= frame_bit(nxt, '0);
        link_doe  <= !frame_listens(nxt, '0);
      end else if (busy && tick) begin
        if (!link_clk) begin
          link_clk <= 1'b1;
          if (sample_ev) shreg <= {link_din, shreg[RD_W-1:1]};
        end else begin
          link_clk <= 1'b0;
          if (done_ev) begin
            busy      <= 1'b0;
            link_dout <= 1'b0;
            link_doe  <= 1'b1;
            if (cur.kind == K_READ) begin
              rd_data  <= shreg;
              rd_valid <= 1'b1;
            end
          end else begin
            idx       <= idx_n;
            link_dout <= frame_bit(cur, idx_n);
            link_doe  <= !frame_listens(cur, idx_n);
          end
        end
      end
    end
  end

endmodule

// File: rtl/prog_link_host.sv
module prog_link_host
  import prog_link_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_period,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [INSN_W-1:0] cmd_word,
  output logic [RD_W-1:0]   rd_data,
  output logic              rd_valid,
  output logic              link_clk,
  output logic              link_dout,
  output logic              link_doe,
  input  logic              link_din
);

  logic              busy;
  logic              accept;
  logic              tick;
  logic              sample_ev;
  logic              done_ev;
  logic [HALF_W-1:0] half_q;
  frame_t            req;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;

  always_comb begin
    req.kind = cmd_read ? K_READ : K_SEND;
    req.lead = 1'b0;
    req.word = cmd_word;
  end

  prog_link_pace #(.HALF_W(HALF_W)) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .half  (half_q),
    .tick  (tick)
  );

  prog_link_frame #(.HALF_W(HALF_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req       (req),
    .half_in   (half_period),
    .tick      (tick),
    .link_din  (link_din),
    .busy      (busy),
    .half_q    (half_q),
    .link_clk  (link_clk),
    .link_dout (link_dout),
    .link_doe  (link_doe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .sample_ev (sample_ev),
    .done_ev   (done_ev)
  );

endmodule

// File: rtl/prog_link_host_chk.sv
module prog_link_host_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic accept,
  input logic tick,
  input logic sample_ev,
  input logic done_ev,
  input logic link_clk,
  input logic link_dout,
  input logic link_doe,
  input logic rd_valid
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!link_clk && link_doe));

  p_start_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_clk_paced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(link_clk));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clk && !tick) |=> ($stable(link_dout) && $stable(link_doe)));

  p_release_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !link_doe |-> busy);

  p_sample_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |=> (link_clk && !link_doe));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_valid_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(done_ev)));

endmodule

bind prog_link_host prog_link_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .accept    (accept),
  .tick      (tick),
  .sample_ev (sample_ev),
  .done_ev   (done_ev),
  .link_clk  (link_clk),
  .link_dout (link_dout),
  .link_doe  (link_doe),
  .rd_valid  (rd_valid)
);

// File: tb/prog_link_host_test.sv
module prog_link_host_test;

  localparam int HW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [HW-1:0] half_period;
  logic          cmd_valid;
  logic          cmd_ready;
  logic          cmd_read;
  logic [23:0]   cmd_word;
  logic [15:0]   rd_data;
  logic          rd_valid;
  logic          link_clk;
  logic          link_dout;
  logic          link_doe;
  logic          link_din;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit first_pend = 1'b1;

  // target model: presents the next readout bit while the line is released
  logic [15:0] tgt_word = 16'h0;
  int          tgt_idx  = 0;
  int          tgt_base = 0;
  logic [3:0]  tgt_off;
  assign tgt_off  = 4'(tgt_idx - tgt_base);
  assign link_din = tgt_word[tgt_off];
  always @(posedge link_clk) if (!link_doe) tgt_idx <= tgt_idx + 1;

  prog_link_host #(.HALF_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_word(cmd_word), .rd_data(rd_data), .rd_valid(rd_valid),
    .link_clk(link_clk), .link_dout(link_dout), .link_doe(link_doe),
    .link_din(link_din)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    first_pend = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !link_clk && link_doe && !link_dout && !rd_valid, "R1",
        "reset idle state", {cmd_ready, link_clk, link_doe, link_dout, rd_valid}, 5'b10100);
  endtask

  task automatic run_cmd(input bit rd, input logic [23:0] w, input int h,
                         input logic [15:0] tw, input bit poke);
    int heff, n, nbusy, nrise, hi_run, badhi, glitch, bitbad, nvalid, guard;
    bit lead, prev, pdout, ok;
    logic [39:0] v;
    heff = (h == 0) ? 1 : h;
    lead = !rd && first_pend;
    n    = rd ? 28 : (lead ? 33 : 28);
    v    = rd ? 40'h1 : (lead ? {7'b0, w, 9'b0} : {12'b0, w, 4'b0});
    tgt_word = tw;
    tgt_base = tgt_idx;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_word = w; half_period = HW'(h);
    @(negedge clk);
    cmd_valid = 1'b0;
    nbusy = 0; nrise = 0; hi_run = 0; badhi = 0; glitch = 0; bitbad = 0;
    nvalid = 0; guard = 0; prev = 1'b0; pdout = link_dout;
    while (!cmd_ready && guard < 5000) begin
      guard++;
      nbusy++;
      if (poke) begin
        cmd_valid = (nbusy >= 3 && nbusy <= 20);
        cmd_read  = 1'b1;
        cmd_word  = 24'h0F0F0F;
      end
      if (link_clk && !prev) begin
        if (nrise < n) begin
          if (rd && nrise >= 12) ok = !link_doe;
          else                   ok = link_doe && (link_dout == v[nrise]);
          if (!ok) bitbad++;
        end
        nrise++;
        hi_run = 0;
      end
      if (link_clk) hi_run++;
      if (!link_clk && prev && hi_run != heff) badhi++;
      if (link_clk && prev && link_dout != pdout) glitch++;
      if (rd_valid) nvalid++;
      prev  = link_clk;
      pdout = link_dout;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    if (prev && hi_run != heff) badhi++;
    chk(nbusy == 2 * heff * n, "R10", "frame cycles (R2 R5 R6)", nbusy, 2 * heff * n);
    chk(nrise == n, rd ? "R7" : (lead ? "R6" : "R5"), "link clocks", nrise, n);
    chk(bitbad == 0, rd ? "R7" : "R4", "bit or direction errors", bitbad, 0);
    chk(badhi == 0, "R2", "high phase length errors", badhi, 0);
    chk(glitch == 0, "R3", "data change while high", glitch, 0);
    chk(nvalid == 0 && rd_valid == rd, "R8", "valid at end", {nvalid, rd_valid}, rd);
    if (rd) chk(rd_data == tw, "R8", "read word", rd_data, tw);
    chk(!link_clk && link_doe && !link_dout, "R1", "idle after frame",
        {link_clk, link_doe, link_dout}, 3'b010);
    @(negedge clk);
    chk(!rd_valid && cmd_ready, "R9", "single pulse, no extra frame", {rd_valid, cmd_ready}, 1);
    if (rd) chk(rd_data == tw, "R8", "read word held", rd_data, tw);
    if (lead) first_pend = 1'b0;
  endtask

  typedef struct packed {
    logic        rd;
    logic [23:0] word;
    logic [3:0]  half;
    logic [15:0] tgt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 24'hA5C3F1, 4'd2, 16'h0000},
    '{1'b0, 24'h000001, 4'd1, 16'h0000},
    '{1'b1, 24'h000000, 4'd3, 16'hBEEF},
    '{1'b0, 24'hFFFFFF, 4'd0, 16'h0000},
    '{1'b1, 24'h000000, 4'd1, 16'h8001},
    '{1'b0, 24'h123456, 4'd4, 16'h0000}
  };

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_word = '0; half_period = '0;
    do_reset();
    // table walk: R4 R5 R6 R7 R8 R10 across divider settings
    for (int i = 0; i < 6; i++)
      run_cmd(VECS[i].rd, VECS[i].word, int'(VECS[i].half), VECS[i].tgt, 1'b0);
    // R6: a read first after reset leaves the lengthened frame pending
    do_reset();
    run_cmd(1'b1, 24'h0, 1, 16'h1234, 1'b0);
    run_cmd(1'b0, 24'h800000, 1, 16'h0, 1'b0);
    run_cmd(1'b0, 24'h5A5A5A, 2, 16'h0, 1'b0);
    // R9: commands offered mid-frame are ignored
    run_cmd(1'b0, 24'hC0FFEE, 3, 16'h0, 1'b1);
    run_cmd(1'b1, 24'h0, 2, 16'h7E81, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule